// File: doc/BRIEF.md
# Dual-Channel High/Low Count PWM Generator

This block drives two independent pulse-width outputs. Each channel's waveform comes from two cycle counts held in a 32-bit count register: a high count, then a low count, repeating. The counts are in units of a divided source clock. Each channel builds that clock from three parts: a selector that picks one of four source-tick inputs, a 7-bit divider, and a gate. One shared control register holds the selector, divider and gate of both channels, plus one output enable bit per channel.

Software programs the counts and the control word through a simple word-addressed register bus. There is no polarity control, so an inverted waveform is made by swapping the two counts. The four source inputs are single-cycle tick strobes in the system clock domain. A high level in a cycle counts as one source-clock cycle.

Top module: `pwm2_top`

## Requirements
- R1: After synchronous reset, every register reads zero and both outputs are low.
- R2: Count register A is at byte offset 0x0, count register B at 0x4 and the control register at 0x8. Each reads back exactly the last value written. A write to any other address, including 0xC, has no effect, and reads there return zero.
- R3: In a count register, bits 31:16 are the high count and bits 15:0 the low count. An enabled channel drives high for the high count, then low for the low count, and repeats.
- R4: A low count of zero still gives one low count per period. A high count of zero keeps the output low.
- R5: Control bits 14:8 (channel A) and 22:16 (channel B) are the divider fields. A value N makes each count last N+1 selected source ticks.
- R6: Control bits 5:4 (A) and 7:6 (B) select source tick input 0 to 3 as the channel's clock.
- R7: Control bit 0 (A) and bit 1 (B) enable the outputs. Clearing an enable bit drives that output low in the cycle after the write, even in mid-period.
- R8: Control bit 15 (A) and bit 23 (B) are clock gates. While a gate is clear, that channel's output is low and its count is frozen. Setting the gate again resumes from the frozen count.
- R9: Setting an enable bit restarts the channel at the start of its high phase. The output is high in the cycle after the write when the high count is nonzero.
- R10: New counts written while a channel runs take effect at the next period boundary. The period already under way finishes with the old counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_tick | input | 4 | Source clock ticks, one bit per source |
| pwm_out | output | 2 | PWM outputs, bit 0 channel A, bit 1 channel B |

## Verification
The hardest state to reach from the ports is a gate cleared in the middle of a high phase while the enable stays set. The count must then freeze part-way and resume from that point.

The stimulus enables a channel at full source rate and counts the high cycles it sees. It then clears the gate, holds it clear, and sets it again. The high cycles before and after the pause must add up to exactly the programmed high count.

Two other cases get their own stimulus. A count update is written during a running high phase, to show that the old period completes first. The maximum high count is run with a zero low count, to show the single low count.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;

    localparam int DATA_W  = 32;
    localparam int CNT_W   = 16;
    localparam int DIV_W   = 7;
    localparam int SEL_W   = 2;
    localparam int NUM_SRC = 1 << SEL_W;
    localparam int NUM_CH  = 2;

    // Control field bases; channel c is offset by c (enable), 2c (select), 8c (div/gate)
    localparam int EN_BASE   = 0;
    localparam int SEL_BASE  = 4;
    localparam int DIV_BASE  = 8;
    localparam int GATE_BASE = 15;

    typedef struct packed {
        logic             gate;
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] sel;
        logic             en;
    } chan_ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } counts_t;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_t;

    function automatic chan_ctrl_t unpack_ctrl(input int ch, input logic [DATA_W-1:0] w);
        chan_ctrl_t c;
        c.en   = w[EN_BASE + ch];
        c.sel  = w[SEL_BASE + SEL_W*ch +: SEL_W];
        c.div  = w[DIV_BASE + 8*ch +: DIV_W];
        c.gate = w[GATE_BASE + 8*ch];
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] low_len(input logic [CNT_W-1:0] lo);
        return (lo == '0) ? CNT_W'(1) : lo;
    endfunction

endpackage

// File: rtl/pwm2_regs.sv
module pwm2_regs
    import pwm2_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output logic [DATA_W-1:0] rdata,
    output counts_t           counts [NUM_CH],
    output chan_ctrl_t        ctrl   [NUM_CH]
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(NUM_CH);

    logic [DATA_W-1:0] cnt_q [NUM_CH];
    logic [DATA_W-1:0] ctrl_q;
    logic [IDX_W-1:0]  idx;
    logic              aligned;

    assign idx     = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            for (int i = 0; i < NUM_CH; i++) cnt_q[i] <= '0;
        end else if (we && aligned) begin
            if (idx == CTRL_IDX) ctrl_q <= wdata;
            for (int i = 0; i < NUM_CH; i++)
                if (idx == IDX_W'(i)) cnt_q[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            if (idx == CTRL_IDX) rdata = ctrl_q;
            for (int i = 0; i < NUM_CH; i++)
                if (idx == IDX_W'(i)) rdata = cnt_q[i];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
        assign counts[g] = counts_t'(cnt_q[g]);
        assign ctrl[g]   = unpack_ctrl(g, ctrl_q);
    end

    // R2: a control write is visible on the next cycle
    assert_ctrl_readback_R2: assert property (@(posedge clk) disable iff (rst)
        (we && aligned && idx == CTRL_IDX) |=> (ctrl_q == $past(wdata)));

endmodule

// File: rtl/pwm2_clkdiv.sv
module pwm2_clkdiv
    import pwm2_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [DIV_W-1:0]   div_i,
    input  logic               gate_i,
    output logic               tick_o
);
    logic [DIV_W-1:0] div_cnt_q;
    logic             src_hit;
    logic             wrap;

    assign src_hit = src_tick[sel_i];
    assign wrap    = (div_cnt_q >= div_i);
    assign tick_o  = gate_i && src_hit && wrap;

    always_ff @(posedge clk) begin
        if (rst || !gate_i)
            div_cnt_q <= '0;
        else if (src_hit)
            div_cnt_q <= wrap ? '0 : div_cnt_q + 1'b1;
    end

    // R8: a closed gate parks the divider
    assert_gate_parks_div_R8: assert property (@(posedge clk) disable iff (rst)
        !gate_i |=> (div_cnt_q == '0));

endmodule

// File: rtl/pwm2_chan.sv
module pwm2_chan
    import pwm2_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en_i,
    input  logic    gate_i,
    input  logic    tick_i,
    input  counts_t reg_counts,
    output logic    pwm_o
);
    phase_t           phase_q;
    counts_t          act_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] lo_len;
    phase_t           start_phase;

    assign cnt_nxt     = cnt_q + 1'b1;
    assign lo_len      = low_len(act_q.lo);
    assign start_phase = (reg_counts.hi != '0) ? PH_HIGH : PH_LOW;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_LOW;
            act_q   <= '0;
            cnt_q   <= '0;
        end else if (!en_i) begin
            act_q   <= reg_counts;
            phase_q <= start_phase;
            cnt_q   <= '0;
        end else if (tick_i) begin
            if (phase_q == PH_HIGH) begin
                if (cnt_nxt == act_q.hi) begin
                    phase_q <= PH_LOW;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_nxt;
                end
            end else begin
                if (cnt_nxt == lo_len) begin
                    act_q   <= reg_counts;
                    phase_q <= start_phase;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_nxt;
                end
            end
        end
    end

    assign pwm_o = en_i && gate_i && (phase_q == PH_HIGH);

    // R3: high phase never runs past its count
    assert_high_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (en_i && phase_q == PH_HIGH) |-> (cnt_q < act_q.hi));

    // R4: low phase lasts at least one count and never past its length
    assert_low_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOW) |-> (cnt_q < lo_len));

    // R9: a disabled channel sits at the start of a period
    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (cnt_q == '0));

    // R8: no counting while the gate is closed
    assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        (en_i && !gate_i) |=> (!en_i || $stable(cnt_q)));

endmodule

// File: rtl/pwm2_top.sv
module pwm2_top
    import pwm2_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_we,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic [NUM_CH-1:0]  pwm_out
);
    counts_t    counts [NUM_CH];
    chan_ctrl_t ctrl   [NUM_CH];

    pwm2_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .we     (bus_we),
        .rdata  (bus_rdata),
        .counts (counts),
        .ctrl   (ctrl)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic tick;

        pwm2_clkdiv u_div (
            .clk      (clk),
            .rst      (rst),
            .src_tick (src_tick),
            .sel_i    (ctrl[c].sel),
            .div_i    (ctrl[c].div),
            .gate_i   (ctrl[c].gate),
            .tick_o   (tick)
        );

        pwm2_chan u_chan (
            .clk        (clk),
            .rst        (rst),
            .en_i       (ctrl[c].en),
            .gate_i     (ctrl[c].gate),
            .tick_i     (tick),
            .reg_counts (counts[c]),
            .pwm_o      (pwm_out[c])
        );
    end

endmodule

// File: tb/pwm2_top_tb.sv
module pwm2_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick;
    logic [1:0]  pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    int fc       = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    always @(negedge clk) fc <= fc + 1;
    assign src_tick = {(fc % 4) == 0, (fc % 3) == 0, (fc % 2) == 0, 1'b1};

    pwm2_top u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .src_tick(src_tick), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    // enable bit c, select 4+2c, divider 8+8c, gate 15+8c
    function automatic logic [31:0] chw(input int c, input bit en, input int sel,
                                        input int dv, input bit gate);
        logic [31:0] w = '0;
        w[c] = en;
        w[4 + 2*c +: 2] = sel[1:0];
        w[8 + 8*c +: 7] = dv[6:0];
        w[15 + 8*c] = gate;
        return w;
    endfunction

    function automatic logic [31:0] cw(input int hi, input int lo);
        return {hi[15:0], lo[15:0]};
    endfunction

    task automatic run_len(input int ch, input logic lvl, output int n);
        n = 0;
        while (pwm_out[ch] == lvl && n < 70000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure(input int ch, output int h, output int l);
        int guard = 0;
        while (pwm_out[ch] == 1'b1 && guard < 70000) begin guard++; @(negedge clk); end
        while (pwm_out[ch] == 1'b0 && guard < 140000) begin guard++; @(negedge clk); end
        run_len(ch, 1'b1, h);
        run_len(ch, 1'b0, l);
    endtask

    task automatic t_reset;
        rd_check("R1 count A", 4'h0, 32'h0);
        rd_check("R1 count B", 4'h4, 32'h0);
        rd_check("R1 ctrl", 4'h8, 32'h0);
        check("R1 outputs", pwm_out, 0);
    endtask

    task automatic t_readback;
        wr(4'h0, 32'hDEAD_BEEF);
        wr(4'h4, 32'h1234_5678);
        wr(4'h8, 32'h00A5_5A3C);
        wr(4'hC, 32'hFFFF_FFFF);
        rd_check("R2 count A", 4'h0, 32'hDEAD_BEEF);
        rd_check("R2 count B", 4'h4, 32'h1234_5678);
        rd_check("R2 ctrl", 4'h8, 32'h00A5_5A3C);
        rd_check("R2 unmapped read", 4'hC, 32'h0);
        @(negedge clk);
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0);
    endtask

    task automatic t_basic;
        int h, l;
        wr(4'h0, cw(3, 5));
        wr(4'h8, chw(0, 1, 0, 0, 1));
        check("R9 high right after enable", pwm_out[0], 1);
        run_len(0, 1'b1, h);
        check("R3/R9 first high run", h, 3);
        run_len(0, 1'b0, l);
        check("R3 low run", l, 5);
        run_len(0, 1'b1, h);
        check("R3 second high run", h, 3);
        wr(4'h8, 32'h0);
    endtask

    task automatic t_divider;
        int h, l;
        wr(4'h0, cw(2, 3));
        wr(4'h8, chw(0, 1, 0, 3, 1));
        measure(0, h, l);
        check("R5 div 3 high", h, 8);
        check("R5 div 3 low", l, 12);
        wr(4'h8, 32'h0);
    endtask

    task automatic t_source;
        int h, l;
        wr(4'h0, cw(3, 2));
        wr(4'h4, cw(2, 3));
        wr(4'h8, chw(0, 1, 2, 1, 1) | chw(1, 1, 1, 2, 1));
        measure(0, h, l);
        check("R6 A src2 div1 high", h, 18);
        check("R6 A src2 div1 low", l, 12);
        measure(1, h, l);
        check("R6 B src1 div2 high", h, 12);
        check("R6 B src1 div2 low", l, 18);
        wr(4'h8, 32'h0);
    endtask

    task automatic t_disable;
        int stuck = 0;
        wr(4'h0, cw(20, 20));
        wr(4'h8, chw(0, 1, 0, 0, 1));
        repeat (5) @(negedge clk);
        check("R7 high before disable", pwm_out[0], 1);
        wr(4'h8, chw(0, 0, 0, 0, 1));
        check("R7 low right after disable", pwm_out[0], 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pwm_out[0]) stuck++;
        end
        check("R7 stays low", stuck, 0);
        wr(4'h8, 32'h0);
    endtask

    task automatic t_gate;
        int hc = 0, stuck = 0, rest;
        wr(4'h0, cw(10, 10));
        wr(4'h8, chw(0, 1, 0, 0, 1));
        if (pwm_out[0]) hc++;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (pwm_out[0]) hc++;
        end
        wr(4'h8, chw(0, 1, 0, 0, 0));
        check("R8 low with gate clear", pwm_out[0], 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (pwm_out[0]) stuck++;
        end
        check("R8 held low while gated", stuck, 0);
        wr(4'h8, chw(0, 1, 0, 0, 1));
        run_len(0, 1'b1, rest);
        check("R8 resumed high total", hc + rest, 10);
        wr(4'h8, 32'h0);
    endtask

    task automatic t_update;
        int h, l;
        wr(4'h0, cw(4, 4));
        wr(4'h8, chw(0, 1, 0, 0, 1));
        wr(4'h0, cw(2, 6));
        run_len(0, 1'b1, h);
        check("R10 current high keeps old count", h + 1, 4);
        run_len(0, 1'b0, l);
        check("R10 current low keeps old count", l, 4);
        run_len(0, 1'b1, h);
        check("R10 next high uses new count", h, 2);
        run_len(0, 1'b0, l);
        check("R10 next low uses new count", l, 6);
        wr(4'h8, 32'h0);
    endtask

    task automatic t_lowzero;
        int h, l, seen = 0;
        wr(4'h0, cw(5, 0));
        wr(4'h8, chw(0, 1, 0, 0, 1));
        measure(0, h, l);
        check("R4 lo zero high", h, 5);
        check("R4 lo zero gives one low", l, 1);
        wr(4'h8, 32'h0);
        wr(4'h0, cw(0, 0));
        wr(4'h8, chw(0, 1, 0, 0, 1));
        for (int i = 0; i < 20; i++) begin
            if (pwm_out[0]) seen++;
            @(negedge clk);
        end
        check("R4 hi zero stays low", seen, 0);
        wr(4'h8, 32'h0);
        wr(4'h0, cw(16'hFFFF, 0));
        wr(4'h8, chw(0, 1, 0, 0, 1));
        run_len(0, 1'b1, h);
        check("R4 max high run", h, 65535);
        run_len(0, 1'b0, l);
        check("R4 max high single low", l, 1);
        wr(4'h8, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readback();
        t_basic();
        t_divider();
        t_source();
        t_disable();
        t_gate();
        t_update();
        t_lowzero();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule